// File: doc/BRIEF.md
# Exception Cause and Return-Address Controller

This block sits beside the step sequencer of a multicycle processor control unit and adds exception handling. It watches for two faults: an opcode that the decoder does not recognise, seen during the decode step, and an arithmetic overflow reported by the ALU during the register-to-register execute step. When either is seen, the block spends exactly one cycle in an exception step. In that step it writes a 32-bit cause register and a 32-bit return-address register, steers the PC multiplexer to its fourth input, which carries the fixed handler address C0000000 hex, and blocks the register-file write that the normal sequence would perform.

The return address is not held in a separate adder. The PC has already been advanced by 4 during fetch, so during the exception step the datapath ALU is set up to compute PC minus 4. The block captures that ALU result into the return-address register. An overflowing instruction is not rolled back: its result still reaches the ALU output register, but it never reaches the register file. In the cycle after the exception step, the block hands control back to the ordinary sequence, which resumes at fetch.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `exc_active`, `epc_wr` and `cause_wr` are 0. `cause_q` and `epc_q` are 0. `pc_src` equals `pc_src_in` and `reg_wr` equals `reg_wr_in`.
- R2: If `undef_op` is 1 while `step` is 1 (the decode step), the next cycle is an exception cycle. In that cycle `exc_active`, `epc_wr` and `cause_wr` are 1.
- R3: If `alu_ovf` is 1 while `step` is 6 (the register-to-register execute step) and the decode rule of R2 does not apply, the next cycle is an exception cycle.
- R4: At the clock edge that ends an exception cycle, `cause_q` is loaded. Bit 0 is 0 for an undefined opcode and 1 for an overflow, and bits 31..1 are 0.
- R5: At the clock edge that ends an exception cycle, `epc_q` is loaded with the value of `alu_result` in that cycle (PC minus 4).
- R6: During an exception cycle `reg_wr` is 0 whatever `reg_wr_in` is. In every other cycle `reg_wr` equals `reg_wr_in`.
- R7: `undef_op` and `alu_ovf` have no effect at any step other than the ones named in R2 and R3.
- R8: If both flags are 1 in the decode step, the exception is recorded as an undefined opcode (cause bit 0 = 0).
- R9: During an exception cycle `pc_src` is binary 11, which selects the handler address. In every other cycle `pc_src` equals `pc_src_in`, and `cause_q` and `epc_q` hold their values.
- R10: An exception cycle lasts exactly one cycle. Flags presented during it are ignored, and the next cycle is a normal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 4 | Current step of the multicycle sequencer |
| undef_op | input | 1 | Decoder reports an unrecognised opcode |
| alu_ovf | input | 1 | ALU reports signed overflow |
| alu_result | input | 32 | ALU output; PC minus 4 during the exception cycle |
| pc_src_in | input | 2 | PC source select from the normal control |
| reg_wr_in | input | 1 | Register-file write enable from the normal control |
| epc_wr | output | 1 | Return-address register write enable |
| cause_wr | output | 1 | Cause register write enable |
| pc_src | output | 2 | PC source select after exception override |
| reg_wr | output | 1 | Register-file write enable after suppression |
| exc_active | output | 1 | High during the single exception cycle |
| cause_q | output | 32 | Cause register |
| epc_q | output | 32 | Return-address register |

## Verification
The bench sweeps every step code with every combination of the two flags. After each combination it presents a second set of flags while the block would be in the exception cycle, so a design that re-armed itself from the exception cycle would stretch the redirect over two cycles and write a second cause. Overflow at the decode step and a bad opcode at the execute step are both covered. A design that decoded the step loosely would raise spurious exceptions, and one that let overflow win the simultaneous case would record cause 1 instead of 0. The bench also drives a different ALU value and write request in every cycle. This exposes a return address captured one cycle off, and a write-back that leaks through the exception cycle.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int                 XLEN        = 32,
  parameter int                 STEP_W      = 4,
  parameter logic [STEP_W-1:0]  DECODE_STEP = 4'd1,
  parameter logic [STEP_W-1:0]  RALU_STEP   = 4'd6,
  parameter logic [1:0]         VEC_SEL     = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              undef_op,
  input  logic              alu_ovf,
  input  logic [XLEN-1:0]   alu_result,
  input  logic [1:0]        pc_src_in,
  input  logic              reg_wr_in,
  output logic              epc_wr,
  output logic              cause_wr,
  output logic [1:0]        pc_src,
  output logic              reg_wr,
  output logic              exc_active,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   epc_q
);

  logic exc_q;
  logic kind_q;
  logic hit_undef;
  logic hit_ovf;

  assign hit_undef = (step == DECODE_STEP) && undef_op;
  assign hit_ovf   = (step == RALU_STEP) && alu_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q  <= 1'b0;
      kind_q <= 1'b0;
    end else if (exc_q) begin
      exc_q  <= 1'b0;
    end else if (hit_undef) begin
      exc_q  <= 1'b1;
      kind_q <= 1'b0;
    end else if (hit_ovf) begin
      exc_q  <= 1'b1;
      kind_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else if (exc_q) begin
      cause_q <= {{(XLEN-1){1'b0}}, kind_q};
      epc_q   <= alu_result;
    end
  end

  assign exc_active = exc_q;
  assign epc_wr     = exc_q;
  assign cause_wr   = exc_q;
  assign pc_src     = exc_q ? VEC_SEL : pc_src_in;
  assign reg_wr     = reg_wr_in & ~exc_q;

  assert_entry_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_active && step == DECODE_STEP && undef_op) |=> (exc_active && cause_wr && epc_wr));

  assert_entry_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_active && step == RALU_STEP && alu_ovf) |=> exc_active);

  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_active |=> !exc_active);

  assert_no_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_active |-> !reg_wr);

  assert_cause_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_active |=> (cause_q[XLEN-1:1] == '0));

  assert_epc_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_active |=> (epc_q == $past(alu_result)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_active |=> ($stable(cause_q) && $stable(epc_q)));

endmodule

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  step = '0;
  logic        undef_op = 1'b0;
  logic        alu_ovf = 1'b0;
  logic [31:0] alu_result = '0;
  logic [1:0]  pc_src_in = '0;
  logic        reg_wr_in = 1'b0;
  logic        epc_wr, cause_wr, reg_wr, exc_active;
  logic [1:0]  pc_src;
  logic [31:0] cause_q, epc_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_exc = 1'b0;
  bit          m_kind = 1'b0;
  logic [31:0] m_cause = '0;
  logic [31:0] m_epc = '0;
  string       cur_tag = "R7";

  exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .step(step), .undef_op(undef_op),
    .alu_ovf(alu_ovf), .alu_result(alu_result), .pc_src_in(pc_src_in),
    .reg_wr_in(reg_wr_in), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .pc_src(pc_src), .reg_wr(reg_wr), .exc_active(exc_active),
    .cause_q(cause_q), .epc_q(epc_q)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] s, input bit u, input bit o,
                     input logic [31:0] res, input logic [1:0] pin, input bit wr);
    @(negedge clk);
    step = s; undef_op = u; alu_ovf = o; alu_result = res; pc_src_in = pin; reg_wr_in = wr;
    #2;
    chk(exc_active == m_exc, cur_tag, {31'b0, exc_active}, {31'b0, m_exc});
    chk(epc_wr == m_exc && cause_wr == m_exc, "R2", {30'b0, epc_wr, cause_wr}, {30'b0, m_exc, m_exc});
    chk(pc_src == (m_exc ? 2'b11 : pin), "R9", {30'b0, pc_src}, {30'b0, (m_exc ? 2'b11 : pin)});
    chk(reg_wr == (wr && !m_exc), "R6", {31'b0, reg_wr}, {31'b0, (wr && !m_exc)});
    chk(cause_q == m_cause, "R4", cause_q, m_cause);
    chk(epc_q == m_epc, "R5", epc_q, m_epc);
    @(posedge clk);
    if (m_exc) begin
      m_cause = {31'b0, m_kind};
      m_epc   = res;
      m_exc   = 1'b0;
    end else if (s == 4'd1 && u) begin
      m_exc = 1'b1; m_kind = 1'b0;
    end else if (s == 4'd6 && o) begin
      m_exc = 1'b1; m_kind = 1'b1;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    pc_src_in = 2'b01; reg_wr_in = 1'b1;
    #2;
    chk(exc_active == 0 && epc_wr == 0 && cause_wr == 0, "R1", {29'b0, exc_active, epc_wr, cause_wr}, 32'h0);
    chk(cause_q == 0 && epc_q == 0, "R1", cause_q | epc_q, 32'h0);
    chk(pc_src == 2'b01 && reg_wr == 1'b1, "R1", {29'b0, pc_src, reg_wr}, 32'h3);
    rst_n = 1'b1;
    @(posedge clk);

    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 4; f++) begin
        bit u, o;
        logic [31:0] base;
        u = f[0]; o = f[1];
        base = 32'h4000_0000 + 32'(s * 64 + f * 16);
        if (s == 1 && u && o)  cur_tag = "R8";
        else if (s == 1 && u)  cur_tag = "R2";
        else if (s == 6 && o)  cur_tag = "R3";
        else                   cur_tag = "R7";
        cyc(4'(s), u, o, base, 2'(s), 1'b1);
        cur_tag = "R10";
        cyc(4'd6, 1'b1, 1'b1, base + 32'h4, 2'(f), 1'b1);
        cur_tag = "R10";
        cyc(4'd0, 1'b0, 1'b0, base + 32'h8, 2'(s + f), 1'(s));
        cur_tag = "R7";
        cyc(4'd0, 1'b0, 1'b0, base + 32'hC, 2'b10, 1'b0);
      end
    end

    cur_tag = "R3";
    cyc(4'd6, 1'b0, 1'b1, 32'h1234_5678, 2'b00, 1'b1);
    cyc(4'd7, 1'b0, 1'b0, 32'h0040_0010, 2'b00, 1'b1);
    cyc(4'd0, 1'b0, 1'b0, 32'hDEAD_BEEF, 2'b00, 1'b0);
    chk(cause_q == 32'h1, "R4", cause_q, 32'h1);
    chk(epc_q == 32'h0040_0010, "R5", epc_q, 32'h0040_0010);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule